// File: doc/BRIEF.md
# Serial Register Access Interface

This block is a synchronous serial slave that lets a host reach a bank of 64 byte-wide registers over four wires. The host selects the slave with an active-low select, toggles a serial clock and presents a 16-clock frame. The frame is made of four parts in this order:

- one direction bit;
- a 6-bit register number;
- one bit that carries nothing;
- one data byte.

A write frame places the byte into the chosen register. A read frame sends the chosen register back on the serial output while the host clocks the byte field. The lower 60 addresses hold configuration bytes that drive the block's outputs. The top 4 addresses show status inputs, such as lock, signal-loss and overflow flags, and cannot be written.

The serial pins are oversampled by a faster system clock. They pass through a synchronizer, and their edges are detected in the system domain, so all state is in a single clock domain. Serial input is taken on rising serial clock edges. Serial output changes after falling edges, so the host can sample it on the next rising edge.

Top module: `sra_serial_regs`

## Requirements
- R1: After reset every configuration byte is 0x00, and `sdo` and `sdo_oe` are low.
- R2: A frame of at least 16 serial clocks with direction bit 0 stores its byte into the addressed configuration register. The frame is sent MSB first: serial clock 1 is the direction bit, clocks 2 to 7 are address bits 5 down to 0, clock 8 is the spare bit, and clocks 9 to 16 are data bits 7 down to 0. Configuration address N appears on `cfg_q[8N+7:8N]`.
- R3: A frame with direction bit 1 returns the addressed byte MSB first on `sdo`. Bit 7 is valid at serial rising edge 9 and bit 0 at edge 16, and `sdo_oe` is high from the falling edge after clock 8 through the falling edge after clock 15.
- R4: The value of the bit on serial clock 8 has no effect on the address, the stored byte or the returned byte.
- R5: If the select goes inactive before the 16th rising serial edge, the frame is dropped and no register changes.
- R6: Addresses 60 to 63 read back `stat_in` bytes, where address 60+K returns `stat_in[8K+7:8K]`. A write to these addresses changes no configuration output.
- R7: `sdo_oe` and `sdo` stay low while the select is inactive, during clocks 1 to 8 of any frame, and throughout write frames.
- R8: Serial clocks after the 16th in a frame are ignored, and they cause no second write.
- R9: Each new assertion of the select starts a fresh frame at clock 1, including right after an aborted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| stat_in | input | 32 | Four read-only status bytes, mapped at addresses 60 to 63 |
| sdo | output | 1 | Serial read data (held low when not driven) |
| sdo_oe | output | 1 | High while `sdo` carries read data |
| cfg_q | output | 480 | Sixty configuration bytes, packed with address 0 in the low bits |

## Verification
The hardest situations to reach are those where the frame ends at an unusual moment. These are a select that goes inactive after the 15th clock, and a frame that runs on past the 16th clock. In both, a register must stay unchanged or must take its value only once. The stimulus task takes a clock count for each frame, so frames of 12, 15 and 20 clocks are driven with patterns that would visibly corrupt a register. A full frame then follows at once, to show that the counter restarted. A behavioural model of the register array is compared against `cfg_q` on every idle clock. Each read is checked against the model and the status inputs.

// File: rtl/sra_pkg.sv
// Package for the serial register access block.
// Holds the frame geometry shared by the frame engine, the register bank and the checker.
// Assumes a frame of: direction bit, address, one spare bit, data.
package sra_pkg;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 8;
    localparam int HDR_LEN   = 1 + ADDR_W + 1;
    localparam int FRAME_LEN = HDR_LEN + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
endpackage

// File: rtl/sra_sync.sv
// Multi-stage synchronizer for a group of asynchronous pins.
// Assumes each pin is independent and slow relative to clk (oversampling).
// The reset value is a parameter so idle-high pins reset to their idle level.
module sra_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_r [STAGES];

    // Shift the pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_r[i] <= RST_VAL;
        end else begin
            stage_r[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_r[i] <= stage_r[i-1];
        end
    end

    assign q = stage_r[STAGES-1];
endmodule

// File: rtl/sra_frame.sv
// Frame engine: counts serial clock edges, collects the header and the data byte,
// issues one write pulse on the final rising edge of a write frame, and shifts read
// data out after falling edges during the data phase of a read frame.
// Assumes synchronized pins; edges are found by comparing against a delayed copy.
module sra_frame
    import sra_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_sclk,
    input  logic              cs_act,
    input  logic              s_sdi,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam logic [CNT_W-1:0] C_HDR_LAST = CNT_W'(HDR_LEN - 1);
    localparam logic [CNT_W-1:0] C_HDR      = CNT_W'(HDR_LEN);
    localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] C_END      = CNT_W'(FRAME_LEN);

    logic                 sclk_d;
    logic                 rise, fall;
    logic [FRAME_LEN-1:0] sh_r;
    logic                 is_rd;
    logic [DATA_W-1:0]    rd_sh;

    assign rise = s_sclk & ~sclk_d;
    assign fall = ~s_sclk & sclk_d;

    // Frame state: edge history, bit counter, header capture, write pulse, output shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            bit_cnt <= '0;
            sh_r    <= '0;
            is_rd   <= 1'b0;
            rd_addr <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
            rd_sh   <= '0;
        end else begin
            sclk_d <= s_sclk;
            wr_en  <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
                sdo     <= 1'b0;
                sdo_oe  <= 1'b0;
            end else begin
                if (rise && bit_cnt < C_END) begin
                    sh_r    <= {sh_r[FRAME_LEN-2:0], s_sdi};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == C_HDR_LAST) begin
                        is_rd   <= sh_r[ADDR_W];
                        rd_addr <= sh_r[ADDR_W-1:0];
                    end
                    if (bit_cnt == C_LAST && !is_rd) begin
                        wr_en   <= 1'b1;
                        wr_addr <= rd_addr;
                        wr_data <= {sh_r[DATA_W-2:0], s_sdi};
                    end
                end
                if (fall) begin
                    if (is_rd && bit_cnt == C_HDR) begin
                        sdo    <= rd_data[DATA_W-1];
                        rd_sh  <= {rd_data[DATA_W-2:0], 1'b0};
                        sdo_oe <= 1'b1;
                    end else if (is_rd && bit_cnt > C_HDR && bit_cnt < C_END) begin
                        sdo    <= rd_sh[DATA_W-1];
                        rd_sh  <= {rd_sh[DATA_W-2:0], 1'b0};
                    end else begin
                        sdo    <= 1'b0;
                        sdo_oe <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sra_regbank.sv
// Register bank: NUM_CFG writable configuration bytes at the low addresses and
// NUM_STAT read-only status bytes at the top of the address space.
// Assumes NUM_CFG + NUM_STAT equals the address space; status writes are dropped.
module sra_regbank
    import sra_pkg::*;
#(
    parameter int NUM_STAT = 4,
    parameter int NUM_CFG  = (1 << ADDR_W) - NUM_STAT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    input  logic [NUM_STAT*DATA_W-1:0] stat_in,
    output logic [NUM_CFG*DATA_W-1:0]  cfg_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cfg_r  [NUM_CFG];
    logic [DATA_W-1:0] rd_tab [DEPTH];

    // Store a committed write into the matching configuration byte only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CFG; i++) cfg_r[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_CFG; i++)
                if (wr_addr == ADDR_W'(i)) cfg_r[i] <= wr_data;
        end
    end

    // Build the read view: configuration bytes below, status bytes on top.
    for (genvar g = 0; g < DEPTH; g++) begin : g_map
        if (g < NUM_CFG) begin : g_cfg
            assign rd_tab[g] = cfg_r[g];
            assign cfg_q[g*DATA_W +: DATA_W] = cfg_r[g];
        end else begin : g_stat
            assign rd_tab[g] = stat_in[(g-NUM_CFG)*DATA_W +: DATA_W];
        end
    end

    assign rd_data = rd_tab[rd_addr];
endmodule

// File: rtl/sra_serial_regs.sv
// Top of the serial register access block.
// Synchronizes the serial pins into clk, runs the frame engine and holds the bank.
// Assumes the serial clock is at most one sixth of clk so each level lasts several cycles.
module sra_serial_regs
    import sra_pkg::*;
#(
    parameter int NUM_STAT    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int NUM_CFG     = (1 << ADDR_W) - NUM_STAT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk,
    input  logic                       cs_n,
    input  logic                       sdi,
    input  logic [NUM_STAT*DATA_W-1:0] stat_in,
    output logic                       sdo,
    output logic                       sdo_oe,
    output logic [NUM_CFG*DATA_W-1:0]  cfg_q
);
    logic [2:0]        pins_s;
    logic              cs_act;
    logic [CNT_W-1:0]  bit_cnt;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    sra_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_s)
    );

    assign cs_act = ~pins_s[2];

    sra_frame u_frame (
        .clk(clk), .rst_n(rst_n), .s_sclk(pins_s[1]), .cs_act(cs_act), .s_sdi(pins_s[0]),
        .rd_data(rd_data), .rd_addr(rd_addr), .bit_cnt(bit_cnt), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    sra_regbank #(.NUM_STAT(NUM_STAT), .NUM_CFG(NUM_CFG)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .stat_in(stat_in), .cfg_q(cfg_q)
    );
endmodule

// File: rtl/sra_checker.sv
// Protocol checker for sra_serial_regs, attached with bind.
// Watches the frame counter, write pulse, output enable and configuration outputs.
module sra_checker
    import sra_pkg::*;
#(
    parameter int CFG_W = 480
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_act,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             wr_en,
    input logic             sdo,
    input logic             sdo_oe,
    input logic [CFG_W-1:0] cfg_q
);
    AST_WR_LAST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> bit_cnt == CNT_W'(FRAME_LEN)); // R2
    AST_OE_DATA_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> bit_cnt == CNT_W'(HDR_LEN)); // R3
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!sdo_oe && !sdo)); // R7
    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_LEN)); // R8
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> bit_cnt == '0); // R9
endmodule

bind sra_serial_regs sra_checker #(.CFG_W(NUM_CFG*sra_pkg::DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .bit_cnt(bit_cnt),
    .wr_en(wr_en), .sdo(sdo), .sdo_oe(sdo_oe), .cfg_q(cfg_q)
);

// File: tb/sra_serial_regs_bench.sv
module sra_serial_regs_bench;
    localparam int H     = 6;    // serial half period in clk cycles
    localparam int NCFG  = 60;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic [31:0]       stat_in = 32'hA53C0F81;
    logic              sdo, sdo_oe;
    logic [NCFG*8-1:0] cfg_q;

    int errors = 0, checks = 0, idle = 0;
    logic [7:0] model [NCFG];
    logic [7:0] got;
    bit         oe_bad;

    always #4 clk = ~clk;

    sra_serial_regs u_sra_serial_regs (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .stat_in(stat_in), .sdo(sdo), .sdo_oe(sdo_oe), .cfg_q(cfg_q)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NCFG*8-1:0] model_flat();
        logic [NCFG*8-1:0] v;
        for (int i = 0; i < NCFG; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    // Reference comparison on every idle clock: outputs match the model, serial output quiet.
    always @(negedge clk) begin
        if (!rst_n || !cs_n) idle <= 0;
        else idle <= idle + 1;
        if (rst_n && cs_n && idle >= 6) begin
            chk(cfg_q == model_flat(), "R2/R5/R6 cfg_q vs model", 32'(cfg_q), 32'(model_flat()));
            chk(!sdo_oe && !sdo, "R7 quiet while deselected", {sdo_oe, sdo}, 0);
        end
    end

    // Drive one frame of nclk serial clocks; collects read bits and flags enable misuse.
    task automatic frame(input bit rd, input logic [5:0] a, input bit dmy, input logic [7:0] d,
                         input int nclk, output logic [7:0] rb, output bit bad);
        logic [15:0] fr;
        fr  = {rd, a, dmy, d};
        rb  = '0;
        bad = 1'b0;
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int k = 1; k <= nclk; k++) begin
            sdi = (k <= 16) ? fr[16-k] : ~d[k%8];
            repeat (H) @(negedge clk);
            if (k >= 9 && k <= 16) rb = {rb[6:0], sdo};
            if (k <= 8 && sdo_oe) bad = 1'b1;
            if (!rd && sdo_oe) bad = 1'b1;
            if (rd && k >= 9 && k <= 16 && !sdo_oe) bad = 1'b1;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        if (!rd && nclk >= 16 && a < 6'(NCFG)) model[a] = d;
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d, input bit dmy, input int n, input string tag);
        frame(1'b0, a, dmy, d, n, got, oe_bad);
        chk(!oe_bad, {tag, " R7 no drive in write frame"}, oe_bad, 0);
    endtask

    task automatic rd_chk(input logic [5:0] a, input bit dmy, input int n, input logic [7:0] exp, input string tag);
        frame(1'b1, a, dmy, 8'h00, n, got, oe_bad);
        chk(got == exp, tag, got, exp);
        chk(!oe_bad, {tag, " R3/R7 enable window"}, oe_bad, 0);
    endtask

    initial begin
        for (int i = 0; i < NCFG; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_q == '0, "R1 cfg after reset", 32'(cfg_q), 0);
        chk(!sdo && !sdo_oe, "R1 serial out after reset", {sdo_oe, sdo}, 0);
        repeat (10) @(negedge clk);

        wr(6'd3, 8'h5A, 1'b0, 16, "R2 write a3");
        rd_chk(6'd3, 1'b0, 16, 8'h5A, "R3 read a3");
        wr(6'd0, 8'h81, 1'b0, 16, "R2 write a0");
        wr(6'd59, 8'hC3, 1'b0, 16, "R2 write a59");
        rd_chk(6'd59, 1'b0, 16, 8'hC3, "R3 read a59");
        rd_chk(6'd0, 1'b0, 16, 8'h81, "R3 read a0");

        wr(6'd10, 8'h7E, 1'b1, 16, "R4 write spare=1");
        rd_chk(6'd10, 1'b1, 16, 8'h7E, "R4 read spare=1");
        rd_chk(6'd10, 1'b0, 16, 8'h7E, "R4 read spare=0");

        wr(6'd3, 8'hFF, 1'b0, 12, "R5 abort at 12");
        rd_chk(6'd3, 1'b0, 16, 8'h5A, "R5 unchanged after 12-clock abort");
        wr(6'd3, 8'h00, 1'b0, 15, "R5 abort at 15");
        wr(6'd4, 8'h33, 1'b0, 16, "R9 frame right after abort");
        rd_chk(6'd3, 1'b0, 16, 8'h5A, "R5 unchanged after 15-clock abort");
        rd_chk(6'd4, 1'b0, 16, 8'h33, "R9 fresh frame after abort");

        rd_chk(6'd60, 1'b0, 16, 8'h81, "R6 status a60");
        rd_chk(6'd63, 1'b0, 16, 8'hA5, "R6 status a63");
        wr(6'd62, 8'h00, 1'b0, 16, "R6 write to status");
        rd_chk(6'd62, 1'b0, 16, 8'h3C, "R6 status a62 after write");
        stat_in = 32'h12345678;
        repeat (4) @(negedge clk);
        rd_chk(6'd61, 1'b0, 16, 8'h56, "R6 status follows input");

        wr(6'd20, 8'h96, 1'b0, 20, "R8 write with 20 clocks");
        rd_chk(6'd20, 1'b0, 16, 8'h96, "R8 no second write");
        rd_chk(6'd20, 1'b0, 20, 8'h96, "R8 read with 20 clocks");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule